// File: doc/BRIEF.md
# Processor Core Power-State Controller

This block tracks the low-power state of one processor core. The core sends single-cycle requests to enter a halt powerdown or a monitor-wait powerdown. The system can ask to stop the clock at any time with an active-low request. A set of wake sources brings the core back to normal run. Stopping the clock moves the block to a stop-grant state. While in stop-grant, the block remembers which state it came from and goes back to that state once the request is released.

The system-side inputs are asynchronous, and each one passes through a two-stage synchronizer. The address-wrap mask input is edge-detected, so only a change of its level counts as a wake. The core-side pulses, the monitor event, the return from a system-management handler, the snoop request and the core reset request are all synchronous to `clk`. The outputs are the encoded state, a clock enable for the core, and a snoop acknowledge.

Top module: `core_pwr_ctl`

## Requirements
- R1: While `rst_n` is low and after its release, `pstate` is 2'b00 (run), `core_clk_en` is 1 and `snoop_ack` is 0.
- R2: The `pstate` encoding is run=2'b00, halt=2'b01, monitor-wait=2'b10 and stop-grant=2'b11. `core_clk_en` is 1 only while `pstate` is run.
- R3: In run, a `halt_pulse` moves the block to halt at the next edge, and a `mwait_pulse` moves it to monitor-wait.
- R4: In halt, any of `init_req`, `intr_req`, `nmi_req`, `probe_req`, `smi_req` or `lapic_irq` returns the block to run. This happens at the third edge after the input rises, because of two synchronizer stages and the state register.
- R5: A change of `addr_wrap_mask` in either direction wakes the block from halt at the third edge. A level held steady does not wake it.
- R6: Monitor-wait returns to run on a wake source (R4/R5) or a `mon_event` pulse, but only while the stop-clock request is not asserted. Otherwise the block stays put.
- R7: `stpclk_n` low moves the block from run, halt or monitor-wait to stop-grant at the third edge.
- R8: In stop-grant, wake sources are ignored. Once `stpclk_n` is high again, the block returns at the third edge to the state it had before stop-grant.
- R9: `core_reset_req` high moves the block to run at the next edge from any state. The remembered pre-stop-grant state is also set to run.
- R10: In run, a `smi_done` pulse moves the block to halt if `smi_to_halt` is 1, and leaves it in run if `smi_to_halt` is 0.
- R11: `snoop_ack` is 1 one cycle after `snoop_req` is 1 while in halt, and 0 otherwise.
- R12: In run, the priority is: stop-clock request first, then `smi_done`, then `halt_pulse`, then `mwait_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_pulse | input | 1 | Core halt request, one cycle |
| mwait_pulse | input | 1 | Core monitor-wait entry, one cycle |
| smi_done | input | 1 | System-management handler return, one cycle |
| smi_to_halt | input | 1 | Return target for smi_done: 1 halt, 0 run |
| mon_event | input | 1 | Monitored-address event, one cycle |
| core_reset_req | input | 1 | Synchronous core reset request |
| stpclk_n | input | 1 | Async stop-clock request, active low |
| addr_wrap_mask | input | 1 | Async address-wrap mask level |
| init_req | input | 1 | Async init wake |
| intr_req | input | 1 | Async maskable interrupt |
| nmi_req | input | 1 | Async non-maskable interrupt |
| probe_req | input | 1 | Async probe request |
| smi_req | input | 1 | Async system-management interrupt |
| lapic_irq | input | 1 | Async local interrupt-controller interrupt |
| snoop_req | input | 1 | Bus snoop request |
| pstate | output | 2 | Current power state |
| core_clk_en | output | 1 | Core clock enable |
| snoop_ack | output | 1 | Snoop acknowledge |

## Verification
The properties assume that the core-side pulses, `mon_event`, `smi_done`, `snoop_req` and `core_reset_req` are synchronous to `clk`. They are stated against the synchronized stop and wake signals inside the block, so they say nothing about the raw asynchronous timing. The stimulus changes every input just after a falling edge. It holds each asynchronous level for at least three edges and lets the synchronizers settle before it starts the next scenario, so every expected state change lands on a known edge.

// File: rtl/core_pwr_pkg.sv
// Shared types and bit positions for the core power-state controller.
// Assumes: the synchronized input vector uses the index layout below.
package core_pwr_pkg;

    typedef enum logic [1:0] {
        PS_RUN   = 2'b00,
        PS_HALT  = 2'b01,
        PS_MWAIT = 2'b10,
        PS_STGNT = 2'b11
    } pstate_e;

    localparam int SYNC_STAGES = 2;
    localparam int NUM_LVL_WAKE = 6;
    localparam int SYNC_W = NUM_LVL_WAKE + 2;
    localparam int IDX_STOP_N = 0;
    localparam int IDX_AWRAP = 1;
    localparam int IDX_LVL_LO = 2;
    localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << IDX_STOP_N;

endpackage

// File: rtl/cpc_sync.sv
// Multi-stage synchronizer for a vector of asynchronous levels.
// Assumes: each bit is an independent level, held for at least STAGES+1 cycles.
module cpc_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift each stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= RST_VAL;
                end else if (s == 0) begin
                    chain[s] <= async_in;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/cpc_wake_detect.sv
// Forms the stop request and the combined wake condition from synchronized inputs.
// Assumes: inputs are already synchronized; address-wrap counts only on a level change.
module cpc_wake_detect
    import core_pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SYNC_W-1:0] sync_vec,
    output logic              stop_req,
    output logic              halt_break
);
    logic awrap_prev;
    logic awrap_edge;
    logic lvl_any;

    // Remember the last synchronized address-wrap level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            awrap_prev <= 1'b0;
        end else begin
            awrap_prev <= sync_vec[IDX_AWRAP];
        end
    end

    // Combine the edge and the level wake sources.
    always_comb begin
        awrap_edge = sync_vec[IDX_AWRAP] ^ awrap_prev;
        lvl_any    = |sync_vec[IDX_LVL_LO +: NUM_LVL_WAKE];
        halt_break = awrap_edge | lvl_any;
        stop_req   = ~sync_vec[IDX_STOP_N];
    end
endmodule

// File: rtl/cpc_state_fsm.sv
// Power-state machine with a remembered return state for stop-grant.
// Assumes: pulses and core_reset_req are synchronous; stop_req/halt_break synchronized.
module cpc_state_fsm
    import core_pwr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    core_reset_req,
    input  logic    stop_req,
    input  logic    halt_break,
    input  logic    halt_pulse,
    input  logic    mwait_pulse,
    input  logic    mon_event,
    input  logic    smi_done,
    input  logic    smi_to_halt,
    input  logic    snoop_req,
    output pstate_e state,
    output logic    snoop_ack
);
    pstate_e state_nxt;
    pstate_e ret_q;
    pstate_e ret_nxt;

    // Next-state and return-state selection.
    always_comb begin
        state_nxt = state;
        ret_nxt   = ret_q;
        if (core_reset_req) begin
            state_nxt = PS_RUN;
            ret_nxt   = PS_RUN;
        end else begin
            unique case (state)
                PS_RUN: begin
                    if (stop_req) begin
                        state_nxt = PS_STGNT;
                        ret_nxt   = PS_RUN;
                    end else if (smi_done) begin
                        state_nxt = smi_to_halt ? PS_HALT : PS_RUN;
                    end else if (halt_pulse) begin
                        state_nxt = PS_HALT;
                    end else if (mwait_pulse) begin
                        state_nxt = PS_MWAIT;
                    end
                end
                PS_HALT: begin
                    if (stop_req) begin
                        state_nxt = PS_STGNT;
                        ret_nxt   = PS_HALT;
                    end else if (halt_break) begin
                        state_nxt = PS_RUN;
                    end
                end
                PS_MWAIT: begin
                    if (stop_req) begin
                        state_nxt = PS_STGNT;
                        ret_nxt   = PS_MWAIT;
                    end else if (halt_break || mon_event) begin
                        state_nxt = PS_RUN;
                    end
                end
                PS_STGNT: begin
                    if (!stop_req) begin
                        state_nxt = ret_q;
                    end
                end
                default: state_nxt = PS_RUN;
            endcase
        end
    end

    // State, return-state and snoop-acknowledge registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PS_RUN;
            ret_q     <= PS_RUN;
            snoop_ack <= 1'b0;
        end else begin
            state     <= state_nxt;
            ret_q     <= ret_nxt;
            snoop_ack <= snoop_req && (state == PS_HALT);
        end
    end
endmodule

// File: rtl/core_pwr_ctl.sv
// Top of the core power-state controller: synchronizers, wake logic, state machine.
// Assumes: system-side inputs are asynchronous; core-side inputs are synchronous to clk.
module core_pwr_ctl
    import core_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_pulse,
    input  logic       mwait_pulse,
    input  logic       smi_done,
    input  logic       smi_to_halt,
    input  logic       mon_event,
    input  logic       core_reset_req,
    input  logic       stpclk_n,
    input  logic       addr_wrap_mask,
    input  logic       init_req,
    input  logic       intr_req,
    input  logic       nmi_req,
    input  logic       probe_req,
    input  logic       smi_req,
    input  logic       lapic_irq,
    input  logic       snoop_req,
    output logic [1:0] pstate,
    output logic       core_clk_en,
    output logic       snoop_ack
);
    logic [SYNC_W-1:0] raw_vec;
    logic [SYNC_W-1:0] sync_vec;
    logic              stop_req;
    logic              halt_break;
    pstate_e           state;

    assign raw_vec = {lapic_irq, smi_req, probe_req, nmi_req, intr_req, init_req,
                      addr_wrap_mask, stpclk_n};

    cpc_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(raw_vec),
        .sync_out(sync_vec)
    );

    cpc_wake_detect u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_vec  (sync_vec),
        .stop_req  (stop_req),
        .halt_break(halt_break)
    );

    cpc_state_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .core_reset_req(core_reset_req),
        .stop_req      (stop_req),
        .halt_break    (halt_break),
        .halt_pulse    (halt_pulse),
        .mwait_pulse   (mwait_pulse),
        .mon_event     (mon_event),
        .smi_done      (smi_done),
        .smi_to_halt   (smi_to_halt),
        .snoop_req     (snoop_req),
        .state         (state),
        .snoop_ack     (snoop_ack)
    );

    assign pstate      = state;
    assign core_clk_en = (state == PS_RUN);
endmodule

// File: rtl/cpc_checker.sv
// Property checker for core_pwr_ctl, attached with bind.
// Assumes: core-side inputs are synchronous; stop/wake observed after synchronization.
module cpc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       core_reset_req,
    input logic       halt_pulse,
    input logic       smi_done,
    input logic       mon_event,
    input logic       snoop_req,
    input logic       stop_req,
    input logic       halt_break,
    input logic [1:0] pstate,
    input logic       snoop_ack
);
    logic [1:0] last_live;

    // Track the last state seen outside stop-grant.
    always_ff @(posedge clk) begin
        if (!rst_n || core_reset_req) begin
            last_live <= 2'b00;
        end else if (pstate != 2'b11) begin
            last_live <= pstate;
        end
    end

    AST_RESET_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset_req |=> pstate == 2'b00); // R9

    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_reset_req && pstate == 2'b00 && !stop_req && !smi_done && halt_pulse)
        |=> pstate == 2'b01); // R3

    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_reset_req && pstate != 2'b11 && stop_req) |=> pstate == 2'b11); // R7

    AST_STGNT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_reset_req && pstate == 2'b11 && !stop_req) |=> pstate == last_live); // R8

    AST_MWAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_reset_req && pstate == 2'b10 && !stop_req && !halt_break && !mon_event)
        |=> pstate == 2'b10); // R6

    AST_SNOOP_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_ack |-> ($past(pstate) == 2'b01 && $past(snoop_req))); // R11
endmodule

bind core_pwr_ctl cpc_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_reset_req(core_reset_req),
    .halt_pulse    (halt_pulse),
    .smi_done      (smi_done),
    .mon_event     (mon_event),
    .snoop_req     (snoop_req),
    .stop_req      (stop_req),
    .halt_break    (halt_break),
    .pstate        (pstate),
    .snoop_ack     (snoop_ack)
);

// File: tb/core_pwr_ctl_tb.sv
// Directed bench for core_pwr_ctl: one task per scenario.
module core_pwr_ctl_tb;
    localparam logic [1:0] RUN = 2'b00, HALT = 2'b01, MWAIT = 2'b10, SG = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_pulse = 0, mwait_pulse = 0, smi_done = 0, smi_to_halt = 0;
    logic mon_event = 0, core_reset_req = 0, stpclk_n = 1, addr_wrap_mask = 0;
    logic [5:0] wk = '0;
    logic snoop_req = 0;
    logic [1:0] pstate;
    logic core_clk_en, snoop_ack;
    int n_vec = 0, n_bad = 0;

    always #5 clk = ~clk;

    core_pwr_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .halt_pulse(halt_pulse), .mwait_pulse(mwait_pulse),
        .smi_done(smi_done), .smi_to_halt(smi_to_halt), .mon_event(mon_event),
        .core_reset_req(core_reset_req), .stpclk_n(stpclk_n),
        .addr_wrap_mask(addr_wrap_mask), .init_req(wk[0]), .intr_req(wk[1]),
        .nmi_req(wk[2]), .probe_req(wk[3]), .smi_req(wk[4]), .lapic_irq(wk[5]),
        .snoop_req(snoop_req), .pstate(pstate), .core_clk_en(core_clk_en),
        .snoop_ack(snoop_ack)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic go_halt();
        halt_pulse = 1; tick(1); halt_pulse = 0;
        chk("R3 halt entry", pstate, HALT);
        chk("R2 clk_en off in halt", core_clk_en, 0);
    endtask

    task automatic t_reset();
        chk("R1 state in reset", pstate, RUN);
        rst_n = 1; tick(1);
        chk("R1 state after reset", pstate, RUN);
        chk("R1 clk_en after reset", core_clk_en, 1);
        chk("R1 snoop_ack after reset", snoop_ack, 0);
    endtask

    task automatic t_halt_wake();
        for (int i = 0; i < 6; i++) begin
            go_halt();
            snoop_req = 1; tick(1);
            chk("R11 ack in halt", snoop_ack, 1);
            snoop_req = 0; tick(1);
            chk("R11 ack drops", snoop_ack, 0);
            wk[i] = 1; tick(2);
            chk("R4 still halt after two edges", pstate, HALT);
            tick(1);
            chk("R4 wake source to run", pstate, RUN);
            chk("R2 clk_en in run", core_clk_en, 1);
            wk[i] = 0; tick(3);
        end
        snoop_req = 1; tick(1);
        chk("R11 no ack in run", snoop_ack, 0);
        snoop_req = 0; tick(1);
    endtask

    task automatic t_addr_wrap();
        go_halt();
        addr_wrap_mask = 1; tick(3);
        chk("R5 rising change wakes", pstate, RUN);
        tick(2);
        go_halt();
        tick(5);
        chk("R5 steady level ignored", pstate, HALT);
        addr_wrap_mask = 0; tick(3);
        chk("R5 falling change wakes", pstate, RUN);
        tick(2);
    endtask

    task automatic t_mwait();
        mwait_pulse = 1; tick(1); mwait_pulse = 0;
        chk("R3 mwait entry", pstate, MWAIT);
        tick(4);
        chk("R6 mwait holds without wake", pstate, MWAIT);
        mon_event = 1; tick(1); mon_event = 0;
        chk("R6 monitor event wakes", pstate, RUN);
        mwait_pulse = 1; tick(1); mwait_pulse = 0;
        stpclk_n = 0; tick(3);
        chk("R7 mwait to stop-grant", pstate, SG);
        mon_event = 1; tick(1); mon_event = 0;
        chk("R6 monitor event blocked by stop", pstate, SG);
        stpclk_n = 1; tick(3);
        chk("R8 return to mwait", pstate, MWAIT);
        wk[2] = 1; tick(3);
        chk("R6 wake source ends mwait", pstate, RUN);
        wk[2] = 0; tick(3);
    endtask

    task automatic t_stop();
        stpclk_n = 0; tick(3);
        chk("R7 run to stop-grant", pstate, SG);
        chk("R2 clk_en off in stop-grant", core_clk_en, 0);
        stpclk_n = 1; tick(3);
        chk("R8 return to run", pstate, RUN);
        go_halt();
        stpclk_n = 0; tick(3);
        chk("R7 halt to stop-grant", pstate, SG);
        wk[1] = 1; tick(4);
        chk("R8 wake ignored in stop-grant", pstate, SG);
        wk[1] = 0; tick(3);
        stpclk_n = 1; tick(3);
        chk("R8 return to halt", pstate, HALT);
        wk[0] = 1; tick(3); wk[0] = 0; tick(3);
        chk("R4 back to run", pstate, RUN);
    endtask

    task automatic t_core_reset();
        go_halt();
        stpclk_n = 0; tick(3);
        chk("R7 halt to stop-grant", pstate, SG);
        core_reset_req = 1; tick(1); core_reset_req = 0;
        chk("R9 reset from stop-grant", pstate, RUN);
        tick(1);
        chk("R7 stop re-enters stop-grant", pstate, SG);
        stpclk_n = 1; tick(3);
        chk("R9 remembered state cleared", pstate, RUN);
        mwait_pulse = 1; tick(1); mwait_pulse = 0;
        core_reset_req = 1; tick(1); core_reset_req = 0;
        chk("R9 reset from mwait", pstate, RUN);
    endtask

    task automatic t_smi();
        smi_to_halt = 1; smi_done = 1; tick(1); smi_done = 0;
        chk("R10 smi return to halt", pstate, HALT);
        wk[3] = 1; tick(3); wk[3] = 0; tick(3);
        smi_to_halt = 0; smi_done = 1; tick(1); smi_done = 0;
        chk("R10 smi return to run", pstate, RUN);
    endtask

    task automatic t_priority();
        halt_pulse = 1; mwait_pulse = 1; tick(1); halt_pulse = 0; mwait_pulse = 0;
        chk("R12 halt over mwait", pstate, HALT);
        wk[5] = 1; tick(3); wk[5] = 0; tick(3);
        smi_to_halt = 0; smi_done = 1; halt_pulse = 1; tick(1);
        smi_done = 0; halt_pulse = 0;
        chk("R12 smi_done over halt", pstate, RUN);
        stpclk_n = 0; tick(2);
        smi_to_halt = 1; smi_done = 1; halt_pulse = 1; tick(1);
        smi_done = 0; halt_pulse = 0; smi_to_halt = 0;
        chk("R12 stop over smi_done and halt", pstate, SG);
        stpclk_n = 1; tick(3);
        chk("R12 returns to run", pstate, RUN);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        t_reset();
        t_halt_wake();
        t_addr_wrap();
        t_mwait();
        t_stop();
        t_core_reset();
        t_smi();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule